// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is a full-duplex SPI master that runs from byte banks rather than single registers. A producer loads up to sixteen bytes into one of two transmit banks and commits that bank with a byte count. The producer may then fill the other bank while the shift engine sends the first one. Each byte sent on MOSI is matched by a byte sampled from MISO. The received bytes go into one of two receive banks, which a consumer reads and then hands back.

The engine works in SPI mode 0 and sends the most significant bit first. The serial clock comes from a programmable divider of the module clock. A programmable guard delay of idle cycles separates consecutive bytes. Chip select stays low for the whole of one bank. Between two banks it returns high for a short gap. The engine then goes on to the second bank without a new start command.

There are three sticky interrupt causes: a byte has completed, the engine has been idle too long, and received data was lost. Each cause has its own enable bit and is cleared by writing 1. The enabled causes are merged onto one interrupt line.

Top module: `spi_pingpong_master`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, busy is 0, and tx_ready, rx_full, irq_flags and irq are all 0.
- R2: A commit with a count from 1 to 16 sets tx_ready[bank]. The block ignores a commit with count 0, a commit with count above 16, and a commit to a bank that is already ready. It also ignores byte writes into a bank that is ready, so the bytes sent are the ones present at commit time.
- R3: Bytes are shifted MSB first in mode 0. MOSI holds the current bit from before each rising sck edge. MISO is sampled on the rising edge. sck is low whenever cs_n is high.
- R4: The engine sends the bytes of a ready bank in address order from 0 up to count-1. It clears that bank's tx_ready bit after the last byte. If the other bank is ready, the engine continues with it and takes a 1-cycle cs_n high gap between the two banks. The first bank chosen after start is the bank that follows the last one served; bank 0 is chosen first after reset.
- R5: When a transfer begins, it claims an empty receive bank, alternating between the two. Byte i received during the transfer is stored at address i. At the end of the transfer, rx_full[bank] is set and rx_rd_len shows the count. Pulsing rx_release frees the bank.
- R6: Each sck high phase and each sck low phase within a byte lasts cfg_div+1 module clocks, so successive rising edges are 2*(cfg_div+1) clocks apart.
- R7: The idle time between the last falling sck edge of one byte and the first rising edge of the next grows by exactly cfg_guard clocks compared with cfg_guard = 0.
- R8: irq_flags[0] (byte done) is set at the end of every byte. All flags stay set until a 1 is written to the matching irq_clr bit.
- R9: irq_flags[1] (timeout) is set after cfg_timeout consecutive idle cycles. A cfg_timeout of 0 disables the timeout.
- R10: If both receive banks are full when a transfer begins, every byte received during that transfer is discarded. Each discarded byte sets irq_flags[2] (overflow), and the contents of the receive banks stay unchanged.
- R11: irq is 1 exactly when some bit of irq_flags & irq_en is set.
- R12: A start pulse with no ready transmit bank is ignored: busy stays 0, cs_n stays 1 and sck stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_en | input | 1 | Write one byte into a transmit bank |
| tx_wr_bank | input | 1 | Transmit bank selected for the write |
| tx_wr_addr | input | 4 | Byte address inside the bank |
| tx_wr_data | input | 8 | Byte to store |
| tx_commit | input | 1 | Mark a transmit bank ready |
| tx_commit_bank | input | 1 | Bank to commit |
| tx_commit_len | input | 5 | Byte count, 1 to 16 |
| tx_ready | output | 2 | Per-bank ready state |
| rx_rd_bank | input | 1 | Receive bank to read |
| rx_rd_addr | input | 4 | Byte address to read |
| rx_rd_data | output | 8 | Byte at the selected address |
| rx_rd_len | output | 5 | Byte count of the selected receive bank |
| rx_release | input | 1 | Hand a receive bank back to the engine |
| rx_release_bank | input | 1 | Bank to release |
| rx_full | output | 2 | Per-bank full state |
| start | input | 1 | Start pulse |
| cfg_div | input | 8 | Half-period of sck minus one, in clocks |
| cfg_guard | input | 8 | Idle clocks between bytes |
| cfg_timeout | input | 16 | Idle clocks before timeout, 0 disables |
| irq_en | input | 3 | Enable per cause: 0 byte, 1 timeout, 2 overflow |
| irq_clr | input | 3 | Write-1-to-clear per cause |
| irq_flags | output | 3 | Sticky cause flags |
| irq | output | 1 | Merged interrupt |
| busy | output | 1 | Engine serving banks |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
A wrong bank pointer or a wrong byte index shows up within the current transfer. The affected bytes appear in the wrong order or with wrong values on MOSI, and the receive data lands at the wrong address or in the wrong bank. This is visible as soon as the bank is read back.

A stuck ready or full bit shows up at the next start. The engine then stalls, sends a stale bank, or raises overflow without cause. A wrong divider or guard count changes the measured sck edge spacing on the very next byte.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
    typedef enum logic [1:0] {SEQ_IDLE, SEQ_LOAD, SEQ_WAIT, SEQ_GAP} seq_e;
    typedef enum logic [1:0] {SH_IDLE, SH_BITS, SH_GUARD} sh_e;
    localparam int IRQ_BYTE = 0;
    localparam int IRQ_TMO  = 1;
    localparam int IRQ_OVF  = 2;
    localparam int NIRQ     = 3;
endpackage

// File: rtl/spi_pp_clkgen.sv
module spi_pp_clkgen #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt == div);
        if (!run || tick) st_d.cnt = '0;
        else              st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: with a divider above zero, ticks never come back to back
    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/spi_pp_shifter.sv
module spi_pp_shifter
    import spi_pp_pkg::*;
#(
    parameter int DW = 8,
    parameter int GW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] tx_byte,
    input  logic          tick,
    input  logic [GW-1:0] guard,
    input  logic          miso,
    output logic          run,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    typedef struct packed {
        sh_e           st;
        logic [DW-1:0] sh;
        logic [DW-1:0] rx;
        logic [BW-1:0] bits;
        logic          sck;
        logic [GW-1:0] gcnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        unique case (st_q.st)
            SH_IDLE: begin
                if (load) begin
                    st_d.sh   = tx_byte;
                    st_d.bits = '0;
                    st_d.sck  = 1'b0;
                    st_d.st   = SH_BITS;
                end
            end
            SH_BITS: begin
                if (tick) begin
                    if (!st_q.sck) begin
                        st_d.sck = 1'b1;
                        st_d.rx  = {st_q.rx[DW-2:0], miso};
                    end else begin
                        st_d.sck = 1'b0;
                        if (st_q.bits == BW'(DW-1)) begin
                            done      = 1'b1;
                            st_d.gcnt = '0;
                            st_d.st   = (guard == '0) ? SH_IDLE : SH_GUARD;
                        end else begin
                            st_d.bits = st_q.bits + 1'b1;
                            st_d.sh   = {st_q.sh[DW-2:0], 1'b0};
                        end
                    end
                end
            end
            SH_GUARD: begin
                st_d.gcnt = st_q.gcnt + 1'b1;
                if (st_q.gcnt >= guard - 1'b1) st_d.st = SH_IDLE;
            end
            default: st_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: SH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign run     = (st_q.st == SH_BITS);
    assign busy    = (st_q.st != SH_IDLE);
    assign sck     = st_q.sck;
    assign mosi    = st_q.sh[DW-1];
    assign rx_byte = st_q.rx;

    // R4: the sequencer hands over a byte only to an idle shifter
    assert_load_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
    // R3: sck is back low once a byte has finished
    assert_sck_low_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !sck);
endmodule

// File: rtl/spi_pp_banks.sv
module spi_pp_banks #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          commit,
    input  logic          commit_bank,
    input  logic [LW-1:0] commit_len,
    input  logic          eng_bank,
    input  logic [AW-1:0] eng_addr,
    output logic [DW-1:0] eng_data,
    output logic [LW-1:0] eng_len,
    input  logic          tx_done,
    input  logic          tx_done_bank,
    input  logic          rx_wr,
    input  logic          rx_wr_bank,
    input  logic [AW-1:0] rx_wr_addr,
    input  logic [DW-1:0] rx_wr_data,
    input  logic          rx_close,
    input  logic          rx_close_bank,
    input  logic [LW-1:0] rx_close_len,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] rd_len,
    input  logic          rel,
    input  logic          rel_bank,
    output logic [1:0]    tx_rdy,
    output logic [1:0]    rx_full
);
    typedef struct packed {
        logic [1:0][DEPTH-1:0][DW-1:0] txm;
        logic [1:0][DEPTH-1:0][DW-1:0] rxm;
        logic [1:0][LW-1:0]            txlen;
        logic [1:0][LW-1:0]            rxlen;
        logic [1:0]                    txrdy;
        logic [1:0]                    rxfull;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !st_q.txrdy[wr_bank])
            st_d.txm[wr_bank][wr_addr] = wr_data;
        if (commit && !st_q.txrdy[commit_bank] &&
            commit_len != '0 && commit_len <= LW'(DEPTH)) begin
            st_d.txrdy[commit_bank] = 1'b1;
            st_d.txlen[commit_bank] = commit_len;
        end
        if (tx_done) st_d.txrdy[tx_done_bank] = 1'b0;
        if (rx_wr)   st_d.rxm[rx_wr_bank][rx_wr_addr] = rx_wr_data;
        if (rx_close) begin
            st_d.rxfull[rx_close_bank] = 1'b1;
            st_d.rxlen[rx_close_bank]  = rx_close_len;
        end
        if (rel && st_q.rxfull[rel_bank]) st_d.rxfull[rel_bank] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eng_data = st_q.txm[eng_bank][eng_addr];
    assign eng_len  = st_q.txlen[eng_bank];
    assign rd_data  = st_q.rxm[rd_bank][rd_addr];
    assign rd_len   = st_q.rxlen[rd_bank];
    assign tx_rdy   = st_q.txrdy;
    assign rx_full  = st_q.rxfull;

    // R4: the engine releases only a bank that was ready
    assert_release_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> st_q.txrdy[tx_done_bank]);
    // R10: received data never lands in a bank the consumer still owns
    assert_no_write_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |-> !st_q.rxfull[rx_wr_bank]);
endmodule

// File: rtl/spi_pingpong_master.sv
module spi_pingpong_master
    import spi_pp_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int DIVW  = 8,
    parameter int GW    = 8,
    parameter int TW    = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_wr_en,
    input  logic            tx_wr_bank,
    input  logic [AW-1:0]   tx_wr_addr,
    input  logic [DW-1:0]   tx_wr_data,
    input  logic            tx_commit,
    input  logic            tx_commit_bank,
    input  logic [LW-1:0]   tx_commit_len,
    output logic [1:0]      tx_ready,
    input  logic            rx_rd_bank,
    input  logic [AW-1:0]   rx_rd_addr,
    output logic [DW-1:0]   rx_rd_data,
    output logic [LW-1:0]   rx_rd_len,
    input  logic            rx_release,
    input  logic            rx_release_bank,
    output logic [1:0]      rx_full,
    input  logic            start,
    input  logic [DIVW-1:0] cfg_div,
    input  logic [GW-1:0]   cfg_guard,
    input  logic [TW-1:0]   cfg_timeout,
    input  logic [NIRQ-1:0] irq_en,
    input  logic [NIRQ-1:0] irq_clr,
    output logic [NIRQ-1:0] irq_flags,
    output logic            irq,
    output logic            busy,
    output logic            sck,
    output logic            mosi,
    input  logic            miso,
    output logic            cs_n
);
    typedef struct packed {
        seq_e            seq;
        logic            bank;
        logic [AW-1:0]   idx;
        logic            rxb;
        logic            rxv;
        logic            txptr;
        logic            rxptr;
        logic            cs;
        logic [NIRQ-1:0] flags;
        logic [TW-1:0]   tcnt;
    } st_t;

    st_t st_d, st_q;

    logic            tick, sh_run, sh_busy, sh_done, sh_load;
    logic [DW-1:0]   sh_rx, eng_data;
    logic [LW-1:0]   eng_len;
    logic            tx_done, rx_wr, rx_close;
    logic [1:0]      tx_rdy_w, rx_full_w;

    function automatic logic [1:0] pick_rx(input logic [1:0] full, input logic ptr);
        if (!full[ptr])       return {1'b1, ptr};
        else if (!full[~ptr]) return {1'b1, ~ptr};
        else                  return {1'b0, ptr};
    endfunction

    always_comb begin
        logic [1:0] rsel;
        st_d     = st_q;
        sh_load  = 1'b0;
        tx_done  = 1'b0;
        rx_wr    = 1'b0;
        rx_close = 1'b0;
        rsel     = pick_rx(rx_full_w, st_q.rxptr);
        st_d.flags = st_q.flags & ~irq_clr;

        unique case (st_q.seq)
            SEQ_IDLE: begin
                if (start && (tx_rdy_w != 2'b00)) begin
                    st_d.bank = tx_rdy_w[st_q.txptr] ? st_q.txptr : ~st_q.txptr;
                    st_d.idx  = '0;
                    st_d.rxv  = rsel[1];
                    st_d.rxb  = rsel[0];
                    st_d.cs   = 1'b1;
                    st_d.seq  = SEQ_LOAD;
                end
            end
            SEQ_LOAD: begin
                sh_load  = 1'b1;
                st_d.seq = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (sh_done) begin
                    st_d.flags[IRQ_BYTE] = 1'b1;
                    if (st_q.rxv) rx_wr = 1'b1;
                    else          st_d.flags[IRQ_OVF] = 1'b1;
                end
                if (!sh_busy) begin
                    if (LW'(st_q.idx) + LW'(1) >= eng_len) begin
                        tx_done    = 1'b1;
                        rx_close   = st_q.rxv;
                        st_d.txptr = ~st_q.bank;
                        if (st_q.rxv) st_d.rxptr = ~st_q.rxb;
                        st_d.cs    = 1'b0;
                        st_d.seq   = tx_rdy_w[~st_q.bank] ? SEQ_GAP : SEQ_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                        st_d.seq = SEQ_LOAD;
                    end
                end
            end
            SEQ_GAP: begin
                if (tx_rdy_w[st_q.txptr]) begin
                    st_d.bank = st_q.txptr;
                    st_d.idx  = '0;
                    st_d.rxv  = rsel[1];
                    st_d.rxb  = rsel[0];
                    st_d.cs   = 1'b1;
                    st_d.seq  = SEQ_LOAD;
                end else begin
                    st_d.seq = SEQ_IDLE;
                end
            end
            default: st_d.seq = SEQ_IDLE;
        endcase

        if (st_q.seq != SEQ_IDLE) begin
            st_d.tcnt = '0;
        end else if (cfg_timeout != '0) begin
            if (st_q.tcnt == cfg_timeout - TW'(1)) st_d.flags[IRQ_TMO] = 1'b1;
            if (st_q.tcnt < cfg_timeout) st_d.tcnt = st_q.tcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{seq: SEQ_IDLE, default: '0};
        else        st_q <= st_d;
    end

    spi_pp_clkgen #(.DIVW(DIVW)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(sh_run), .div(cfg_div), .tick(tick)
    );

    spi_pp_shifter #(.DW(DW), .GW(GW)) u_shifter (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .tx_byte(eng_data),
        .tick(tick), .guard(cfg_guard), .miso(miso), .run(sh_run),
        .busy(sh_busy), .sck(sck), .mosi(mosi), .done(sh_done), .rx_byte(sh_rx)
    );

    spi_pp_banks #(.DW(DW), .DEPTH(DEPTH)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tx_wr_en), .wr_bank(tx_wr_bank), .wr_addr(tx_wr_addr), .wr_data(tx_wr_data),
        .commit(tx_commit), .commit_bank(tx_commit_bank), .commit_len(tx_commit_len),
        .eng_bank(st_q.bank), .eng_addr(st_q.idx), .eng_data(eng_data), .eng_len(eng_len),
        .tx_done(tx_done), .tx_done_bank(st_q.bank),
        .rx_wr(rx_wr), .rx_wr_bank(st_q.rxb), .rx_wr_addr(st_q.idx), .rx_wr_data(sh_rx),
        .rx_close(rx_close), .rx_close_bank(st_q.rxb), .rx_close_len(eng_len),
        .rd_bank(rx_rd_bank), .rd_addr(rx_rd_addr), .rd_data(rx_rd_data), .rd_len(rx_rd_len),
        .rel(rx_release), .rel_bank(rx_release_bank),
        .tx_rdy(tx_rdy_w), .rx_full(rx_full_w)
    );

    assign tx_ready  = tx_rdy_w;
    assign rx_full   = rx_full_w;
    assign irq_flags = st_q.flags;
    assign irq       = |(st_q.flags & irq_en);
    assign busy      = (st_q.seq != SEQ_IDLE);
    assign cs_n      = ~st_q.cs;

    // R3: no serial clock activity outside chip select
    assert_sck_low_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    // R12: a start with nothing ready leaves the engine idle
    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && tx_ready == 2'b00) |=> !busy);
    // R8: byte flag stays until cleared
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[IRQ_BYTE] && !irq_clr[IRQ_BYTE]) |=> irq_flags[IRQ_BYTE]);
    // R10: overflow flag stays until cleared
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[IRQ_OVF] && !irq_clr[IRQ_OVF]) |=> irq_flags[IRQ_OVF]);
endmodule

// File: tb/spi_pingpong_master_bench.sv
module spi_pingpong_master_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_wr_en = 0, tx_wr_bank = 0, tx_commit = 0, tx_commit_bank = 0;
    logic [3:0] tx_wr_addr = '0, rx_rd_addr = '0;
    logic [7:0] tx_wr_data = '0, cfg_div = 8'd1, cfg_guard = '0;
    logic [4:0] tx_commit_len = '0;
    logic [1:0] tx_ready, rx_full;
    logic rx_rd_bank = 0, rx_release = 0, rx_release_bank = 0, start = 0;
    logic [7:0] rx_rd_data;
    logic [4:0] rx_rd_len;
    logic [15:0] cfg_timeout = '0;
    logic [2:0] irq_en = '0, irq_clr = '0, irq_flags;
    logic irq, busy, sck, mosi, miso, cs_n;

    int total = 0, bad = 0;
    int cyc = 0;
    logic [7:0] cap [0:63];
    int cap_n = 0, bitn = 0, fall_cyc = 0, rise_cyc = 0, last_gap = 0, last_per = 0;
    logic [7:0] shreg = '0;
    int cs_rises = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign miso = ~mosi;

    always @(posedge sck) begin
        if (bitn == 0) last_gap = cyc - fall_cyc;
        else           last_per = cyc - rise_cyc;
        rise_cyc = cyc;
        shreg = {shreg[6:0], mosi};
        bitn++;
        if (bitn == 8) begin
            if (cap_n < 64) cap[cap_n] = shreg;
            cap_n++;
            bitn = 0;
        end
    end
    always @(negedge sck) fall_cyc = cyc;
    always @(posedge cs_n) cs_rises++;

    spi_pingpong_master u_spi_pingpong_master (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed ^ (8'(i) * 8'h1D);
    endfunction

    task automatic put_bank(input bit b, input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_wr_en = 1; tx_wr_bank = b; tx_wr_addr = 4'(i); tx_wr_data = pat(seed, i);
        end
        @(negedge clk);
        tx_wr_en = 0; tx_commit = 1; tx_commit_bank = b; tx_commit_len = 5'(n);
        @(negedge clk);
        tx_commit = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        repeat (3) @(negedge clk);
        while ((busy || !cs_n) && n < 20000) begin @(negedge clk); n++; end
        chk(n < 20000, "R4 engine finished", n, 0);
    endtask

    task automatic rd(input bit b, input int a, output logic [7:0] d, output logic [4:0] len);
        @(negedge clk); rx_rd_bank = b; rx_rd_addr = 4'(a);
        #1; d = rx_rd_data; len = rx_rd_len;
    endtask

    task automatic release_rx(input bit b);
        @(negedge clk); rx_release = 1; rx_release_bank = b;
        @(negedge clk); rx_release = 0;
    endtask

    task automatic clear_flags();
        @(negedge clk); irq_clr = 3'b111;
        @(negedge clk); irq_clr = 3'b000;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n == 1 && sck == 0 && busy == 0, "R1 idle pins", {cs_n, sck, busy}, 3'b100);
        chk(tx_ready == 0 && rx_full == 0, "R1 bank state", {tx_ready, rx_full}, 0);
        chk(irq_flags == 0 && irq == 0, "R1 irq state", {irq_flags, irq}, 0);
    endtask

    task automatic t_start_ignored();
        pulse_start();
        repeat (20) @(negedge clk);
        chk(busy == 0 && cs_n == 1 && sck == 0 && cap_n == 0, "R12 start ignored",
            {busy, cs_n, sck}, 3'b010);
    endtask

    task automatic t_basic();
        logic [7:0] d; logic [4:0] l;
        cfg_div = 8'd1; cfg_guard = 0;
        put_bank(0, 3, 8'hA5);
        put_bank(1, 2, 8'h42);
        chk(tx_ready == 2'b11, "R2 both committed", tx_ready, 3);
        cap_n = 0; cs_rises = 0;
        pulse_start();
        wait_idle();
        chk(cap_n == 5, "R4 byte count", cap_n, 5);
        for (int i = 0; i < 3; i++) chk(cap[i] == pat(8'hA5, i), "R3 R4 bank0 mosi", cap[i], pat(8'hA5, i));
        for (int i = 0; i < 2; i++) chk(cap[3+i] == pat(8'h42, i), "R4 bank1 mosi", cap[3+i], pat(8'h42, i));
        chk(cs_rises == 2, "R4 cs_n gap between banks", cs_rises, 2);
        chk(tx_ready == 0, "R4 banks released", tx_ready, 0);
        chk(rx_full == 2'b11, "R5 rx banks full", rx_full, 3);
        for (int i = 0; i < 3; i++) begin
            rd(0, i, d, l);
            chk(d == ~pat(8'hA5, i) && l == 3, "R5 rx bank0", {l, d}, {5'd3, ~pat(8'hA5, i)});
        end
        rd(1, 1, d, l);
        chk(d == ~pat(8'h42, 1) && l == 2, "R5 rx bank1", {l, d}, {5'd2, ~pat(8'h42, 1)});
        chk(last_per == 4, "R6 period div=1", last_per, 4);
        chk(irq_flags == 3'b001, "R8 byte flag", irq_flags, 1);
    endtask

    task automatic t_irq();
        @(negedge clk); irq_en = 3'b000; #1;
        chk(irq == 0, "R11 masked", irq, 0);
        irq_en = 3'b001; #1;
        chk(irq == 1, "R11 enabled", irq, 1);
        clear_flags();
        chk(irq_flags == 0 && irq == 0, "R8 write one clears", {irq_flags, irq}, 0);
    endtask

    task automatic t_overflow();
        logic [7:0] d; logic [4:0] l;
        put_bank(0, 1, 8'h55);
        cap_n = 0;
        pulse_start();
        wait_idle();
        chk(cap_n == 1 && cap[0] == 8'h55, "R10 byte still sent", cap[0], 8'h55);
        chk(irq_flags[2] == 1, "R10 overflow flag", irq_flags, 3'b101);
        rd(0, 0, d, l);
        chk(d == ~pat(8'hA5, 0) && l == 3, "R10 rx unchanged", {l, d}, {5'd3, ~pat(8'hA5, 0)});
        @(negedge clk); irq_en = 3'b100; #1;
        chk(irq == 1, "R11 overflow irq", irq, 1);
        irq_en = 0;
        release_rx(0); release_rx(1);
        chk(rx_full == 0, "R5 release", rx_full, 0);
        clear_flags();
    endtask

    task automatic t_guard();
        int gap0;
        cfg_div = 8'd2; cfg_guard = 0;
        put_bank(0, 2, 8'h17);
        pulse_start(); wait_idle();
        gap0 = last_gap;
        chk(last_per == 6, "R6 period div=2", last_per, 6);
        release_rx(0); release_rx(1);
        cfg_guard = 8'd7;
        put_bank(1, 2, 8'h17);
        pulse_start(); wait_idle();
        chk(last_gap - gap0 == 7, "R7 guard adds cycles", last_gap - gap0, 7);
        release_rx(0); release_rx(1);
        cfg_guard = 0; cfg_div = 8'd1;
        clear_flags();
    endtask

    task automatic t_commit_rules();
        @(negedge clk); tx_commit = 1; tx_commit_bank = 0; tx_commit_len = 0;
        @(negedge clk); tx_commit = 0;
        chk(tx_ready == 0, "R2 zero count ignored", tx_ready, 0);
        @(negedge clk); tx_commit = 1; tx_commit_len = 5'd17;
        @(negedge clk); tx_commit = 0;
        chk(tx_ready == 0, "R2 count 17 ignored", tx_ready, 0);
        put_bank(0, 1, 8'h66);
        chk(tx_ready == 2'b01, "R2 valid commit", tx_ready, 1);
        @(negedge clk); tx_wr_en = 1; tx_wr_bank = 0; tx_wr_addr = 0; tx_wr_data = 8'h99;
        @(negedge clk); tx_wr_en = 0; tx_commit = 1; tx_commit_bank = 0; tx_commit_len = 5'd5;
        @(negedge clk); tx_commit = 0;
        cap_n = 0;
        pulse_start(); wait_idle();
        chk(cap_n == 1 && cap[0] == 8'h66, "R2 ready bank protected", cap[0], 8'h66);
        release_rx(0); release_rx(1);
        clear_flags();
    endtask

    task automatic t_timeout();
        repeat (60) @(negedge clk);
        chk(irq_flags[1] == 0, "R9 disabled at zero", irq_flags, 0);
        cfg_timeout = 16'd40;
        repeat (20) @(negedge clk);
        chk(irq_flags[1] == 0, "R9 not before limit", irq_flags, 0);
        repeat (30) @(negedge clk);
        chk(irq_flags[1] == 1, "R9 timeout flag", irq_flags, 3'b010);
        @(negedge clk); irq_en = 3'b010; #1;
        chk(irq == 1, "R11 timeout irq", irq, 1);
        cfg_timeout = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_start_ignored();
        t_basic();
        t_irq();
        t_overflow();
        t_guard();
        t_commit_rules();
        t_timeout();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule